// File: doc/BRIEF.md
# Interrupt Pin Trigger and End-of-Interrupt Tracker

This block keeps the request state for a bank of interrupt input pins. Each cycle it samples the raw pin levels and applies each pin's configured polarity. It then decides, per pin and according to edge or level mode, whether the pin must be serviced. Servicing an unmasked pin raises a delivery request. That request is presented one cycle later as a single-cycle pulse carrying the pin index and the pin's vector. Destination resolution happens downstream and is not part of this block.

Level-mode pins use an in-service flag (remote IRR). Delivery sets the flag, and the flag blocks any further delivery of the pin until an end-of-interrupt (EOI) message naming the pin's vector clears it. If the pin is still asserted when the EOI arrives, it is delivered again at once. An edge seen while a pin is masked is dropped rather than stored, so unmasking the pin later does not fire an old edge. The register block upstream pulses a per-pin "entry touched" strobe whenever it rewrites a pin's configuration. A touched pin that is still pending is serviced again under its new settings.

Top module: `irq_pin_tracker`

## Requirements
- R1: After reset no delivery is presented and every remote IRR bit reads 0.
- R2: The effective level of a pin is its raw input XOR its active-low bit (cfg_active_low = 1 means the pin is asserted while the raw input is 0). Only a 0-to-1 change of the effective level counts as a new assertion.
- R3: An edge-mode pin (cfg_level = 0) that is unmasked (cfg_mask = 0) produces exactly one delivery for each new assertion. dlv_valid is high in the cycle that follows the clock edge sampling the assertion, and dlv_vector equals that pin's cfg_vectors slice. A pin held asserted causes no further delivery.
- R4: Delivering a level-mode pin (cfg_level = 1) sets its remote IRR bit. While that bit is set, new assertions of the pin produce no delivery.
- R5: An EOI clears the remote IRR of only the lowest-numbered pin whose vector equals eoi_vector. An EOI whose vector matches no pin changes nothing.
- R6: If the pin selected by an EOI is unmasked and still asserted and pending, it is delivered again and its remote IRR stays set. If the pin is no longer asserted, the EOI causes no delivery.
- R7: An assertion of an edge-mode pin while it is masked is discarded. Unmasking that pin together with an entry-touched strobe produces no delivery.
- R8: A level-mode pin asserted while masked stays pending. Unmasking it together with an entry-touched strobe delivers it and sets its remote IRR.
- R9: When several pins owe a delivery, deliveries are presented on consecutive cycles, one per cycle, in ascending pin order.
- R10: An EOI for a level-mode pin whose remote IRR is set, arriving in the same cycle as a new assertion of that pin, is applied first. The assertion produces exactly one delivery and leaves remote IRR set.
- R11: An entry-touched strobe on a pin that is not pending produces no delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_raw | input | NPINS | Raw interrupt input levels |
| cfg_active_low | input | NPINS | Per-pin polarity, 1 = asserted when low |
| cfg_level | input | NPINS | Per-pin trigger mode, 1 = level, 0 = edge |
| cfg_mask | input | NPINS | Per-pin mask, 1 = masked |
| cfg_vectors | input | NPINS*VEC_W | Per-pin vectors, pin i in bits [i*VEC_W +: VEC_W] |
| cfg_touched | input | NPINS | Per-pin entry-rewritten strobe |
| eoi_valid | input | 1 | End-of-interrupt message valid |
| eoi_vector | input | VEC_W | Vector named by the end-of-interrupt message |
| dlv_valid | output | 1 | Delivery request, one cycle per delivery |
| dlv_pin | output | IDX_W | Index of the pin being delivered |
| dlv_vector | output | VEC_W | Vector of the pin being delivered |
| remote_irr | output | NPINS | Per-pin in-service flags |

## Verification
The bench builds the block with its default values: 24 pins and 8-bit vectors. With those values it drives both the lowest pin (0) and the highest pin (23) in one simultaneous burst, which exercises the whole ascending priority scan from end to end. Two pins are given the same vector so the EOI lowest-match rule can be observed, and every other pin has a distinct vector. A scoreboard checks the order and vector of every delivery against this setup.

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker #(
  parameter int NPINS = 24,
  parameter int VEC_W = 8,
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       pin_raw,
  input  logic [NPINS-1:0]       cfg_active_low,
  input  logic [NPINS-1:0]       cfg_level,
  input  logic [NPINS-1:0]       cfg_mask,
  input  logic [NPINS*VEC_W-1:0] cfg_vectors,
  input  logic [NPINS-1:0]       cfg_touched,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  output logic                   dlv_valid,
  output logic [IDX_W-1:0]       dlv_pin,
  output logic [VEC_W-1:0]       dlv_vector,
  output logic [NPINS-1:0]       remote_irr
);

  logic [NPINS-1:0] eff_q, pend_q, rirr_q, owe_q;
  logic [NPINS-1:0] eoi_hit;

  wire [NPINS-1:0] eff     = pin_raw ^ cfg_active_low;
  wire [NPINS-1:0] rise    = eff & ~eff_q;
  wire [NPINS-1:0] rirr_a  = rirr_q & ~eoi_hit;
  wire [NPINS-1:0] pend_a  = eff & (pend_q | rise);
  wire [NPINS-1:0] trig    = rise & ((~cfg_level & ~pend_q) | ~rirr_a);
  wire [NPINS-1:0] svc     = pend_a & (trig | cfg_touched | eoi_hit);
  wire [NPINS-1:0] deliver = svc & ~cfg_mask;
  wire [NPINS-1:0] issue   = owe_q & (~owe_q + NPINS'(1));

  always_comb begin
    logic found;
    found   = 1'b0;
    eoi_hit = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (!found && eoi_valid && cfg_vectors[i*VEC_W +: VEC_W] == eoi_vector) begin
        eoi_hit[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_comb begin
    dlv_pin = '0;
    for (int i = NPINS-1; i >= 0; i--)
      if (owe_q[i]) dlv_pin = IDX_W'(i);
  end

  assign dlv_valid  = |owe_q;
  assign dlv_vector = cfg_vectors[dlv_pin*VEC_W +: VEC_W];
  assign remote_irr = rirr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eff_q  <= '0;
      pend_q <= '0;
      rirr_q <= '0;
      owe_q  <= '0;
    end else begin
      eff_q  <= eff;
      pend_q <= pend_a & ~(svc & ~cfg_level);
      rirr_q <= rirr_a | (deliver & cfg_level);
      owe_q  <= (owe_q & ~issue) | deliver;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_chk
    // R4
    rirr_rise_owe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rirr_q[g]) |-> owe_q[g]);
    // R4
    rirr_rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rirr_q[g]) |-> $past(cfg_level[g]));
    // R5
    rirr_fall_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rirr_q[g]) |-> ($past(eoi_valid) &&
        $past(eoi_vector) == $past(cfg_vectors[g*VEC_W +: VEC_W])));
    // R7
    owe_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(owe_q[g]) |-> !$past(cfg_mask[g]));
  end

endmodule

// File: tb/irq_pin_tracker_test.sv
module irq_pin_tracker_test;
  localparam int N  = 24;
  localparam int VW = 8;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pin_raw = '0, cfg_active_low = '0, cfg_level = '0;
  logic [N-1:0] cfg_mask = '1, cfg_touched = '0;
  logic [VW-1:0] vtab [N];
  logic [N*VW-1:0] cfg_vectors;
  logic eoi_valid = 1'b0;
  logic [VW-1:0] eoi_vector = '0;
  logic dlv_valid;
  logic [IW-1:0] dlv_pin;
  logic [VW-1:0] dlv_vector;
  logic [N-1:0] remote_irr;

  typedef struct { int pin; int vec; string req; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0, dlv_count = 0;

  always #5 clk = ~clk;

  always_comb for (int i = 0; i < N; i++) cfg_vectors[i*VW +: VW] = vtab[i];

  irq_pin_tracker #(.NPINS(N), .VEC_W(VW)) uut (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .cfg_active_low(cfg_active_low),
    .cfg_level(cfg_level), .cfg_mask(cfg_mask), .cfg_vectors(cfg_vectors),
    .cfg_touched(cfg_touched), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .dlv_valid(dlv_valid), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector),
    .remote_irr(remote_irr));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && dlv_valid) begin
      dlv_count++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R3", "unexpected delivery pin", int'(dlv_pin), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(dlv_pin) == e.pin, e.req, "delivered pin", int'(dlv_pin), e.pin);
        check(int'(dlv_vector) == e.vec, e.req, "delivered vector", int'(dlv_vector), e.vec);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_dlv(input int pin, input string req);
    exp_t e;
    e.pin = pin; e.vec = int'(vtab[pin]); e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic drained(input string req);
    check(exp_q.size() == 0, req, "deliveries still owed", exp_q.size(), 0);
  endtask

  task automatic eoi(input logic [VW-1:0] v);
    eoi_valid = 1'b1; eoi_vector = v;
    tick(1);
    eoi_valid = 1'b0;
  endtask

  task automatic touch(input int pin);
    cfg_touched[pin] = 1'b1;
    tick(1);
    cfg_touched[pin] = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int base;
    for (int i = 0; i < N; i++) vtab[i] = VW'(8'h30 + i);
    tick(3);
    check(dlv_valid == 1'b0, "R1", "dlv_valid in reset", int'(dlv_valid), 0);
    check(remote_irr == '0, "R1", "remote_irr in reset", int'(remote_irr), 0);
    rst_n = 1'b1;
    tick(2);
    check(dlv_valid == 1'b0, "R1", "dlv_valid after reset", int'(dlv_valid), 0);
    check(remote_irr == '0, "R1", "remote_irr after reset", int'(remote_irr), 0);

    // R3: edge pin 2, one delivery per assertion
    cfg_mask[2] = 1'b0;
    expect_dlv(2, "R3");
    pin_raw[2] = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check(dlv_valid == 1'b1, "R3", "dlv_valid one cycle after edge", int'(dlv_valid), 1);
    tick(4);
    drained("R3");
    base = dlv_count;
    tick(4);
    check(dlv_count == base, "R3", "deliveries while held", dlv_count - base, 0);
    pin_raw[2] = 1'b0; tick(2);
    expect_dlv(2, "R3");
    pin_raw[2] = 1'b1; tick(4);
    drained("R3");

    // R2: active-low pin 4
    cfg_mask[4] = 1'b0;
    base = dlv_count;
    pin_raw[4] = 1'b1; cfg_active_low[4] = 1'b1;
    tick(4);
    check(dlv_count == base, "R2", "delivery with raw high active-low", dlv_count - base, 0);
    expect_dlv(4, "R2");
    pin_raw[4] = 1'b0; tick(4);
    drained("R2");

    // R4: level pin 6
    cfg_mask[6] = 1'b0; cfg_level[6] = 1'b1;
    expect_dlv(6, "R4");
    pin_raw[6] = 1'b1; tick(4);
    drained("R4");
    check(remote_irr[6] == 1'b1, "R4", "remote_irr[6] after delivery", int'(remote_irr[6]), 1);
    base = dlv_count;
    pin_raw[6] = 1'b0; tick(2);
    pin_raw[6] = 1'b1; tick(4);
    check(dlv_count == base, "R4", "delivery while in service", dlv_count - base, 0);

    // R6: EOI with pin still asserted redelivers
    expect_dlv(6, "R6");
    eoi(vtab[6]); tick(4);
    drained("R6");
    check(remote_irr[6] == 1'b1, "R6", "remote_irr[6] after redelivery", int'(remote_irr[6]), 1);
    base = dlv_count;
    pin_raw[6] = 1'b0; tick(2);
    eoi(vtab[6]); tick(3);
    check(remote_irr[6] == 1'b0, "R6", "remote_irr[6] after eoi, pin low", int'(remote_irr[6]), 0);
    check(dlv_count == base, "R6", "delivery after eoi, pin low", dlv_count - base, 0);

    // R5: shared vector, lowest match wins
    vtab[5] = 8'h50; vtab[9] = 8'h50;
    cfg_level[5] = 1'b1; cfg_level[9] = 1'b1; cfg_mask[5] = 1'b0; cfg_mask[9] = 1'b0;
    expect_dlv(5, "R5"); expect_dlv(9, "R5");
    pin_raw[5] = 1'b1; pin_raw[9] = 1'b1; tick(5);
    drained("R5");
    pin_raw[5] = 1'b0; pin_raw[9] = 1'b0; tick(2);
    eoi(8'h50); tick(2);
    check(remote_irr[5] == 1'b0, "R5", "remote_irr[5] after eoi", int'(remote_irr[5]), 0);
    check(remote_irr[9] == 1'b1, "R5", "remote_irr[9] after eoi", int'(remote_irr[9]), 1);
    eoi(8'hEE); tick(2);
    check(remote_irr[9] == 1'b1, "R5", "remote_irr[9] after unmatched eoi", int'(remote_irr[9]), 1);
    vtab[5] = 8'h35;
    eoi(8'h50); tick(2);
    check(remote_irr[9] == 1'b0, "R5", "remote_irr[9] after own eoi", int'(remote_irr[9]), 0);

    // R7: masked edge discarded
    base = dlv_count;
    pin_raw[10] = 1'b1; tick(3);
    cfg_mask[10] = 1'b0; touch(10); tick(4);
    check(dlv_count == base, "R7", "delivery of stale edge", dlv_count - base, 0);

    // R8: masked level pin kept pending
    cfg_level[11] = 1'b1;
    pin_raw[11] = 1'b1; tick(4);
    check(dlv_count == base, "R8", "delivery while masked", dlv_count - base, 0);
    expect_dlv(11, "R8");
    cfg_mask[11] = 1'b0; touch(11); tick(4);
    drained("R8");
    check(remote_irr[11] == 1'b1, "R8", "remote_irr[11] after unmask", int'(remote_irr[11]), 1);

    // R11: touch on a non-pending pin
    cfg_mask[12] = 1'b0;
    base = dlv_count;
    touch(12); tick(4);
    check(dlv_count == base, "R11", "delivery on idle touch", dlv_count - base, 0);

    // R9: simultaneous pins in ascending order
    cfg_mask[0] = 1'b0; cfg_mask[13] = 1'b0; cfg_mask[23] = 1'b0;
    expect_dlv(0, "R9"); expect_dlv(13, "R9"); expect_dlv(23, "R9");
    pin_raw[23] = 1'b1; pin_raw[0] = 1'b1; pin_raw[13] = 1'b1;
    tick(6);
    drained("R9");

    // R10: EOI and new assertion in the same cycle
    pin_raw[6] = 1'b1;
    expect_dlv(6, "R10");
    tick(4);
    drained("R10");
    pin_raw[6] = 1'b0; tick(2);
    base = dlv_count;
    expect_dlv(6, "R10");
    pin_raw[6] = 1'b1; eoi(vtab[6]); tick(4);
    drained("R10");
    check(dlv_count - base == 1, "R10", "deliveries for eoi plus assertion", dlv_count - base, 1);
    check(remote_irr[6] == 1'b1, "R10", "remote_irr[6] after same-cycle eoi", int'(remote_irr[6]), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule